// File: doc/BRIEF.md
# Burst-Tagged Write Buffer

This block sits in a memory controller between the agents that issue writes and the path toward DRAM. It keeps pending writes in arrival order, one entry for each DRAM burst. Each entry holds a burst tag, which is the request address with the offset bits inside a burst cleared, along with a byte-enable mask and the burst data. A new write whose burst is already queued folds into that entry. No new slot is used for it. A write to any other burst takes the next free slot at the tail.

Reads can ask whether the buffer already holds the bytes they want. A read first looks for its burst tag. If the tag is present, the read's byte range is compared with the span of the entry, which runs from the lowest enabled byte to the highest. A covered read is answered from the buffer and counted. The consumer on the drain side takes the oldest entry each cycle it asserts ready, and that entry's tag is freed at the same edge.

`BURST_BYTES` must be a power of two. Any other value stops elaboration with an error.

Top module: `wq_burst_buffer`

## Requirements
- R1: The burst tag of an address is the address with its low log2(BURST_BYTES) bits cleared. Writes that differ only in those bits share one entry. Writes that differ above them get separate entries.
- R2: After reset the buffer is empty and all three counters are zero. `occupancy` is 0, `drain_valid` is 0, `wr_ready` is 1 and `rd_resp_valid` is 0.
- R3: No two queued entries carry the same tag. `occupancy` equals the number of distinct bursts queued.
- R4: A write whose tag is queued merges into that entry. Occupancy is unchanged and `merged_cnt` rises by 1. The entry mask becomes the OR of the old mask and the new bytes, and the new bytes overwrite the data lanes they cover.
- R5: A write with no tag match is appended at the tail. Entries leave in arrival order. A write covers byte lanes offset through offset+size-1 of its burst, where offset is the low address bits and 1 <= size and offset+size <= BURST_BYTES. Lane i of `wr_data` is burst byte i. Lanes with no enable hold zero.
- R6: `drain_valid` is high whenever the buffer is not empty. `drain_addr`, `drain_be` and `drain_data` show the head entry. In a cycle with `drain_ready` high the head is removed and its tag is freed, so a later write to that burst allocates a new entry.
- R7: When all DEPTH entries are in use, and the write neither merges nor coincides with a drain, `wr_ready` is 0 and the write is not taken. A merging write is still accepted when the buffer is full.
- R8: A drain of the head and a write to the head's burst in the same cycle: the drain is done first and the write allocates a new entry. `merged_cnt` does not change.
- R9: A read hits only if its tag is queued and entry_start <= read_addr and read_addr+rd_size <= entry_start+entry_size. The result appears on `rd_resp_valid`/`rd_resp_hit` one cycle after `rd_valid`. On a hit, `rd_served_cnt` rises by 1 and `rd_served_bytes` by BURST_BYTES.
- R10: The entry span runs from its lowest enabled byte to its highest, with any gaps counted in. A read outside that span, or to a burst that is not queued, misses and leaves the counters unchanged.
- R11: A read is checked against the buffer contents from before the same cycle's write and drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write request present |
| wr_ready | output | 1 | Write request accepted this cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_size | input | log2(BURST_BYTES)+1 | Write length in bytes |
| wr_data | input | 8*BURST_BYTES | Write data, lane i = burst byte i |
| rd_valid | input | 1 | Read lookup present |
| rd_addr | input | ADDR_W | Read byte address |
| rd_size | input | log2(BURST_BYTES)+1 | Read length in bytes |
| rd_resp_valid | output | 1 | Lookup result valid |
| rd_resp_hit | output | 1 | Lookup served from the buffer |
| drain_valid | output | 1 | Head entry available |
| drain_ready | input | 1 | Consumer takes the head entry |
| drain_addr | output | ADDR_W | Burst-aligned address of the head |
| drain_be | output | BURST_BYTES | Byte enables of the head |
| drain_data | output | 8*BURST_BYTES | Data of the head |
| occupancy | output | log2(DEPTH+1) | Entries in use |
| merged_cnt | output | CNT_W | Writes merged into existing entries |
| rd_served_cnt | output | CNT_W | Reads answered from the buffer |
| rd_served_bytes | output | CNT_W | Bytes credited to answered reads |

## Verification
The write path is driven with three patterns. Sub-burst writes to a fresh burst show that an allocation occurs. Writes to the same burst at a different offset separate merging from allocation. A write at the next burst address shows where one tag ends and the next begins. Reads are tried at an exact match, strictly inside an entry, straddling the end of an entry's span, inside a gap of a merged mask, and at a burst that is not queued, which distinguishes range containment from a plain tag match. A full buffer is tried with a new burst, with a merging write, and with a write that arrives together with a drain. A drain coinciding with a write to the head's burst checks the priority rule, and a read issued in the same cycle as a write to its own burst checks which state the lookup sees.

// File: rtl/wq_pkg.sv
package wq_pkg;
  typedef enum logic [1:0] {
    WA_IDLE  = 2'd0,
    WA_MERGE = 2'd1,
    WA_ALLOC = 2'd2
  } wr_act_e;
endpackage

// File: rtl/wq_tag_cam.sv
module wq_tag_cam #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 29,
  parameter int IDX_W = 2
) (
  input  logic [DEPTH-1:0]            valid,
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]            key,
  output logic [DEPTH-1:0]            hit_vec,
  output logic                        hit,
  output logic [IDX_W-1:0]            hit_idx
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && (tags[g] == key);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/wq_span.sv
module wq_span #(
  parameter int BURST_BYTES = 8,
  parameter int OFF_W = 3
) (
  input  logic [BURST_BYTES-1:0] be,
  output logic [OFF_W-1:0]       lo,
  output logic [OFF_W-1:0]       hi
);
  always_comb begin
    lo = '0;
    for (int i = BURST_BYTES - 1; i >= 0; i--) begin
      if (be[i]) lo = OFF_W'(i);
    end
  end

  always_comb begin
    hi = '0;
    for (int i = 0; i < BURST_BYTES; i++) begin
      if (be[i]) hi = OFF_W'(i);
    end
  end
endmodule

// File: rtl/wq_burst_buffer.sv
module wq_burst_buffer
  import wq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 8,
  parameter int DEPTH       = 4,
  parameter int CNT_W       = 16,
  localparam int OFF_W  = $clog2(BURST_BYTES),
  localparam int SIZE_W = OFF_W + 1,
  localparam int DATA_W = 8 * BURST_BYTES,
  localparam int OCC_W  = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [SIZE_W-1:0]      wr_size,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   rd_valid,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [SIZE_W-1:0]      rd_size,
  output logic                   rd_resp_valid,
  output logic                   rd_resp_hit,
  output logic                   drain_valid,
  input  logic                   drain_ready,
  output logic [ADDR_W-1:0]      drain_addr,
  output logic [BURST_BYTES-1:0] drain_be,
  output logic [DATA_W-1:0]      drain_data,
  output logic [OCC_W-1:0]       occupancy,
  output logic [CNT_W-1:0]       merged_cnt,
  output logic [CNT_W-1:0]       rd_served_cnt,
  output logic [CNT_W-1:0]       rd_served_bytes
);
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int END_W = OFF_W + 2;

  if ((BURST_BYTES < 2) || ((BURST_BYTES & (BURST_BYTES - 1)) != 0)) begin : g_bad_burst
    $error("BURST_BYTES must be a power of two and at least 2");
  end

  logic [DEPTH-1:0][TAG_W-1:0] tag_q;
  logic [DEPTH-1:0]            vld_q;
  logic [BURST_BYTES-1:0]      be_q   [DEPTH];
  logic [DATA_W-1:0]           data_q [DEPTH];
  logic [IDX_W-1:0]            head_q, tail_q;
  logic [OCC_W-1:0]            occ_q;

  function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + IDX_W'(1);
  endfunction

  // write-side lookup
  logic [TAG_W-1:0] w_key;
  logic [DEPTH-1:0] w_hit_vec;
  logic             w_hit;
  logic [IDX_W-1:0] w_idx;
  assign w_key = wr_addr[ADDR_W-1:OFF_W];

  wq_tag_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_wcam (
    .valid(vld_q), .tags(tag_q), .key(w_key),
    .hit_vec(w_hit_vec), .hit(w_hit), .hit_idx(w_idx)
  );

  logic    pop, full, merge_ok, wr_fire;
  wr_act_e act;
  assign pop      = drain_ready && (occ_q != '0);
  assign full     = (occ_q == OCC_W'(DEPTH));
  // a drain of the head wins over a merge into it
  assign merge_ok = w_hit && !(pop && (w_idx == head_q));
  assign wr_ready = merge_ok || !full || pop;
  assign wr_fire  = wr_valid && wr_ready;

  always_comb begin
    if (!wr_fire)      act = WA_IDLE;
    else if (merge_ok) act = WA_MERGE;
    else               act = WA_ALLOC;
  end

  logic [BURST_BYTES-1:0] wr_be;
  logic [DATA_W-1:0]      wr_data_m;
  always_comb begin
    for (int i = 0; i < BURST_BYTES; i++) begin
      wr_be[i] = (i >= int'(wr_addr[OFF_W-1:0])) &&
                 (i < int'(wr_addr[OFF_W-1:0]) + int'(wr_size));
      wr_data_m[8*i +: 8] = wr_be[i] ? wr_data[8*i +: 8] : 8'h00;
    end
  end

  // read-side lookup
  logic [TAG_W-1:0] r_key;
  logic [DEPTH-1:0] r_hit_vec;
  logic             r_hit;
  logic [IDX_W-1:0] r_idx;
  logic [OFF_W-1:0] r_lo, r_hi;
  logic [END_W-1:0] r_end, span_end;
  logic             r_cover;
  assign r_key = rd_addr[ADDR_W-1:OFF_W];

  wq_tag_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_rcam (
    .valid(vld_q), .tags(tag_q), .key(r_key),
    .hit_vec(r_hit_vec), .hit(r_hit), .hit_idx(r_idx)
  );

  wq_span #(.BURST_BYTES(BURST_BYTES), .OFF_W(OFF_W)) u_span (
    .be(be_q[r_idx]), .lo(r_lo), .hi(r_hi)
  );

  assign r_end    = END_W'(rd_addr[OFF_W-1:0]) + END_W'(rd_size);
  assign span_end = END_W'(r_hi) + END_W'(1);
  assign r_cover  = rd_valid && r_hit && (rd_addr[OFF_W-1:0] >= r_lo) && (r_end <= span_end);

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q           <= '0;
      head_q          <= '0;
      tail_q          <= '0;
      occ_q           <= '0;
      merged_cnt      <= '0;
      rd_served_cnt   <= '0;
      rd_served_bytes <= '0;
      rd_resp_valid   <= 1'b0;
      rd_resp_hit     <= 1'b0;
    end else begin
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= ptr_next(head_q);
      end
      if (act == WA_ALLOC) begin
        vld_q[tail_q] <= 1'b1;
        tag_q[tail_q] <= w_key;
        tail_q        <= ptr_next(tail_q);
      end
      if (act == WA_MERGE) merged_cnt <= merged_cnt + CNT_W'(1);
      occ_q <= occ_q + OCC_W'(act == WA_ALLOC) - OCC_W'(pop);
      rd_resp_valid <= rd_valid;
      rd_resp_hit   <= r_cover;
      if (r_cover) begin
        rd_served_cnt   <= rd_served_cnt + CNT_W'(1);
        rd_served_bytes <= rd_served_bytes + CNT_W'(BURST_BYTES);
      end
    end
  end

  // entry payload, no reset
  always_ff @(posedge clk) begin
    if (act == WA_ALLOC) begin
      be_q[tail_q]   <= wr_be;
      data_q[tail_q] <= wr_data_m;
    end else if (act == WA_MERGE) begin
      be_q[w_idx] <= be_q[w_idx] | wr_be;
      for (int b = 0; b < BURST_BYTES; b++) begin
        if (wr_be[b]) data_q[w_idx][8*b +: 8] <= wr_data[8*b +: 8];
      end
    end
  end

  assign drain_valid = (occ_q != '0);
  assign drain_addr  = {tag_q[head_q], {OFF_W{1'b0}}};
  assign drain_be    = be_q[head_q];
  assign drain_data  = data_q[head_q];
  assign occupancy   = occ_q;

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    occ_q <= OCC_W'(DEPTH)); // R3
  AST_TAG_UNIQUE_W: assert property (@(posedge clk) disable iff (rst)
    $onehot0(w_hit_vec)); // R3
  AST_TAG_UNIQUE_R: assert property (@(posedge clk) disable iff (rst)
    $onehot0(r_hit_vec)); // R3
  AST_VALID_EQ_OCC: assert property (@(posedge clk) disable iff (rst)
    $countones(vld_q) == int'(occ_q)); // R3
  AST_MERGE_KEEPS_OCC: assert property (@(posedge clk) disable iff (rst)
    (act == WA_MERGE) && !pop |=> occ_q == $past(occ_q)); // R4
  AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (rst)
    (act == WA_ALLOC) && !pop |=> occ_q == $past(occ_q) + OCC_W'(1)); // R5
  AST_DRAIN_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    pop && (act != WA_ALLOC) |=> occ_q == $past(occ_q) - OCC_W'(1)); // R6
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    wr_valid && full && !w_hit && !drain_ready |-> !wr_ready); // R7
  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_resp_valid); // R9
endmodule

// File: tb/tb_wq_burst_buffer.sv
`timescale 1ns/1ps
module tb_wq_burst_buffer;
  localparam int ADDR_W = 32;
  localparam int BB     = 8;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 16;
  localparam int OFF_W  = $clog2(BB);
  localparam int SIZE_W = OFF_W + 1;
  localparam int DW     = 8 * BB;
  localparam int OCC_W  = $clog2(DEPTH + 1);
  localparam int TAG_W  = ADDR_W - OFF_W;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, wr_valid, wr_ready, rd_valid, rd_resp_valid, rd_resp_hit;
  logic drain_valid, drain_ready;
  logic [ADDR_W-1:0] wr_addr, rd_addr, drain_addr;
  logic [SIZE_W-1:0] wr_size, rd_size;
  logic [DW-1:0] wr_data, drain_data;
  logic [BB-1:0] drain_be;
  logic [OCC_W-1:0] occupancy;
  logic [CNT_W-1:0] merged_cnt, rd_served_cnt, rd_served_bytes;

  wq_burst_buffer #(.ADDR_W(ADDR_W), .BURST_BYTES(BB), .DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_size(wr_size), .wr_data(wr_data), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_size(rd_size), .rd_resp_valid(rd_resp_valid), .rd_resp_hit(rd_resp_hit),
    .drain_valid(drain_valid), .drain_ready(drain_ready), .drain_addr(drain_addr),
    .drain_be(drain_be), .drain_data(drain_data), .occupancy(occupancy),
    .merged_cnt(merged_cnt), .rd_served_cnt(rd_served_cnt), .rd_served_bytes(rd_served_bytes)
  );

  // behavioural reference
  logic [TAG_W-1:0] m_tag[$];
  logic [BB-1:0]    m_be[$];
  logic [DW-1:0]    m_data[$];
  int m_merged, m_served, m_bytes;
  bit m_rv, m_rh;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  task automatic chk(string lbl, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", lbl, act, exp);
    end
  endtask

  function automatic int find(logic [TAG_W-1:0] t);
    for (int i = 0; i < m_tag.size(); i++) if (m_tag[i] == t) return i;
    return -1;
  endfunction

  task automatic drive(bit wv, logic [31:0] wa, int ws, logic [63:0] wd,
                       bit rv, logic [31:0] ra, int rs, bit dr);
    wr_valid = wv; wr_addr = wa; wr_size = SIZE_W'(ws); wr_data = wd;
    rd_valid = rv; rd_addr = ra; rd_size = SIZE_W'(rs); drain_ready = dr;
  endtask

  task automatic step(string tg);
    int k, j, lo, hi, roff, woff;
    bit pop, rdy, rh;
    logic [BB-1:0] nbe;
    logic [DW-1:0] nd;
    #1;
    k = find(wr_addr[ADDR_W-1:OFF_W]);
    pop = drain_ready && (m_tag.size() > 0);
    rdy = (k >= 0 && !(pop && k == 0)) || (m_tag.size() < DEPTH) || pop;
    chk({tg, " wr_ready R7"}, 64'(wr_ready), 64'(rdy));
    rh = 0;
    if (rd_valid) begin
      j = find(rd_addr[ADDR_W-1:OFF_W]);
      if (j >= 0) begin
        lo = -1; hi = -1;
        for (int b = 0; b < BB; b++) if (m_be[j][b]) begin if (lo < 0) lo = b; hi = b; end
        roff = int'(rd_addr[OFF_W-1:0]);
        rh = (roff >= lo) && (roff + int'(rd_size) <= hi + 1);
      end
    end
    if (pop) begin void'(m_tag.pop_front()); void'(m_be.pop_front()); void'(m_data.pop_front()); end
    if (wr_valid && rdy) begin
      woff = int'(wr_addr[OFF_W-1:0]);
      nbe = '0; nd = '0;
      for (int b = 0; b < BB; b++) if (b >= woff && b < woff + int'(wr_size)) begin
        nbe[b] = 1'b1; nd[8*b +: 8] = wr_data[8*b +: 8];
      end
      k = find(wr_addr[ADDR_W-1:OFF_W]);
      if (k >= 0) begin
        m_merged++;
        m_be[k] = m_be[k] | nbe;
        for (int b = 0; b < BB; b++) if (nbe[b]) m_data[k][8*b +: 8] = nd[8*b +: 8];
      end else begin
        m_tag.push_back(wr_addr[ADDR_W-1:OFF_W]); m_be.push_back(nbe); m_data.push_back(nd);
      end
    end
    m_rv = rd_valid; m_rh = rh;
    if (rh) begin m_served++; m_bytes += BB; end
    @(posedge clk);
    @(negedge clk);
    chk({tg, " occupancy R3"}, 64'(occupancy), 64'(m_tag.size()));
    chk({tg, " drain_valid R6"}, 64'(drain_valid), 64'(m_tag.size() > 0));
    if (m_tag.size() > 0) begin
      chk({tg, " drain_addr R5"}, 64'(drain_addr), 64'({m_tag[0], {OFF_W{1'b0}}}));
      chk({tg, " drain_be R4"}, 64'(drain_be), 64'(m_be[0]));
      chk({tg, " drain_data R4"}, 64'(drain_data), 64'(m_data[0]));
    end
    chk({tg, " merged_cnt R4"}, 64'(merged_cnt), 64'(m_merged));
    chk({tg, " served_cnt R9"}, 64'(rd_served_cnt), 64'(m_served));
    chk({tg, " served_bytes R9"}, 64'(rd_served_bytes), 64'(m_bytes));
    chk({tg, " resp_valid R9"}, 64'(rd_resp_valid), 64'(m_rv));
    chk({tg, " resp_hit R10"}, 64'(rd_resp_hit), 64'(m_rh));
  endtask

  task automatic op_w(string tg, logic [31:0] a, int s, logic [63:0] d, bit dr);
    drive(1, a, s, d, 0, 0, 1, dr); step(tg);
  endtask
  task automatic op_r(string tg, logic [31:0] a, int s);
    drive(0, 0, 1, 0, 1, a, s, 0); step(tg);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    m_merged = 0; m_served = 0; m_bytes = 0; m_rv = 0; m_rh = 0;
    rst = 1'b1;
    drive(0, 0, 1, 0, 0, 0, 1, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R2 occupancy", 64'(occupancy), 0);
    chk("R2 drain_valid", 64'(drain_valid), 0);
    chk("R2 wr_ready", 64'(wr_ready), 1);
    chk("R2 resp_valid", 64'(rd_resp_valid), 0);
    chk("R2 counters", 64'({merged_cnt, rd_served_cnt, rd_served_bytes}), 0);
    @(negedge clk);

    op_w("R5 alloc", 32'h100, 4, 64'h1111_2222_3333_4444, 0);
    op_w("R1 R4 merge", 32'h104, 2, 64'hAAAA_BBBB_CCCC_DDDD, 0);
    op_w("R1 next burst", 32'h108, 8, 64'h0123_4567_89AB_CDEF, 0);
    op_r("R9 exact hit", 32'h100, 4);
    op_r("R10 past span", 32'h101, 6);
    op_r("R10 no tag", 32'h300, 1);
    op_r("R9 inner hit", 32'h102, 2);
    op_w("R5 alloc low", 32'h010, 1, 64'h55, 0);
    op_w("R4 merge gap", 32'h016, 2, 64'h7788_0000_0000_0000, 0);
    op_r("R10 gap span", 32'h013, 2);
    op_w("R7 fill", 32'h200, 8, 64'hFEED_FACE_DEAD_BEEF, 0);
    op_w("R7 stall", 32'h400, 1, 64'h9, 0);
    op_w("R7 merge when full", 32'h10A, 1, 64'h0000_0000_00EE_0000, 0);
    drive(1, 32'h400, 1, 64'h42, 1, 32'h400, 1, 1); step("R11 same cycle");
    op_r("R11 later read", 32'h400, 1);
    op_w("R8 drain priority", 32'h10C, 1, 64'h0000_0066_0000_0000, 1);
    for (int i = 0; i < 5; i++) begin
      drive(0, 0, 1, 0, 0, 0, 1, 1); step("R5 drain order");
    end
    op_w("R6 reuse tag", 32'h100, 1, 64'h3, 0);
    drive(0, 0, 1, 0, 0, 0, 1, 1); step("R6 final drain");

    done = 1;
    summary();
    $finish;
  end
endmodule